// File: doc/BRIEF.md
# Divider-based programmable interval timer

This block is a timer peripheral that advances once per base clock cycle. A free-running 16-bit divider counts every cycle, and software sees only its top byte. An 8-bit event counter steps on each falling edge of one selected divider bit. When the event counter wraps past its maximum, it is reloaded from a modulo register after a short fixed delay, and a one-cycle interrupt request is raised at that moment.

Software reaches four byte registers through a flat address/data bus with a write strobe. The registers sit at four consecutive addresses starting at `BASE_ADDR`: offset 0 is the divider view, offset 1 the event counter, offset 2 the modulo value and offset 3 the control byte. Reads are combinational from the addressed register. Writes take effect at the next clock edge. The interrupt output is meant to feed an interrupt controller outside this block.

Top module: `div_timer`

## Requirements
- R1: After reset, the divider, the event counter, the modulo and the control register are all zero, the control register reads 0xF8, and `irq_o` is low.
- R2: The internal 16-bit divider increments on every clock cycle. A read at offset 0 returns the divider's bits 15:8, so the value steps once every 256 cycles.
- R3: A write at offset 0 clears the whole 16-bit divider to zero at that clock edge. The data written has no effect on the result.
- R4: Control bit 2 enables counting, and control bits 1:0 select a divider tap: 00 selects bit 9, 01 bit 3, 10 bit 5 and 11 bit 7. The counting period is therefore 1024, 16, 64 or 256 cycles. The counter increments at the edge that follows the cycle in which the divider shows a multiple of the period.
- R5: With control bit 2 clear, the event counter holds its value.
- R6: When the event counter is at 0xFF and increments, it reads 0x00 for exactly four cycles. It is then loaded from the modulo register. `irq_o` is high for exactly one cycle, the first cycle in which the loaded value is visible.
- R7: A write to the event counter while a reload is pending cancels the reload. The written value stays, and no interrupt is raised.
- R8: A write to the event counter in the same cycle as an increment wins: the written value is stored and the increment is lost.
- R9: Counting is triggered by the falling edge of the enable bit ANDed with the selected tap. Clearing the enable bit while the selected tap is 1 therefore causes one increment.
- R10: The modulo register and control bits 2:0 read back what was written, and control bits 7:3 read as ones. Writes outside the four-address window are ignored, and reads outside the window return 0x00.
- R11: While a reload is pending, counting edges do not change the event counter or restart the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock, one tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write strobe, one write per high cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | One-cycle interrupt request on reload |

## Verification
The hardest case to reach from the ports is a second counting edge that arrives inside the four-cycle reload window. The natural tap periods are all longer than that window. The stimulus builds the edge by hand instead. It clears the divider, waits until bit 9 is high, and then toggles the enable bit with back-to-back control writes. The first enable-off causes the wrap. The second one falls inside the window, and the reload is then checked to deliver exactly the modulo value. The cancel and write-priority cases use the same cycle bookkeeping from the divider clear, so that a write lands on the exact cycle of a tick or of a pending reload.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NUM_TAPS = 4;

  typedef enum logic [1:0] {
    RegDiv = 2'd0,
    RegCnt = 2'd1,
    RegMod = 2'd2,
    RegCtl = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       en;
    logic [1:0] rate;
  } ctl_t;

  // divider bit watched for each rate code
  function automatic int unsigned tap_bit(input int unsigned rate);
    case (rate)
      0:       return 9;
      1:       return 3;
      2:       return 5;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/timer_divider.sv
module timer_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [DIV_W-1:0] div_o
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  assign div_o = div_q;
endmodule

// File: rtl/timer_tap_edge.sv
module timer_tap_edge #(
  parameter int unsigned NUM_TAPS = 4,
  localparam int unsigned SEL_W = $clog2(NUM_TAPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TAPS-1:0] taps_i,
  input  logic                en_i,
  input  logic [SEL_W-1:0]    rate_i,
  output logic                tick_o
);
  logic gated, gated_q;

  // enable is folded in before edge detection
  assign gated = en_i & taps_i[rate_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gated_q <= 1'b0;
    else         gated_q <= gated;
  end

  assign tick_o = gated_q & ~gated;
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int unsigned W     = 8,
  parameter int unsigned DELAY = 4,
  localparam int unsigned DLY_W = $clog2(DELAY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [W-1:0]     mod_i,
  output logic [W-1:0]     cnt_o,
  output logic [DLY_W-1:0] dly_o,
  output logic             irq_o
);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(DELAY);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(1);

  logic [W-1:0]     cnt_q;
  logic [DLY_W-1:0] dly_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dly_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_i) begin
        cnt_q <= wdata_i;
        dly_q <= '0;
      end else if (dly_q != '0) begin
        dly_q <= dly_q - 1'b1;
        if (dly_q == DLY_LAST) begin
          cnt_q <= mod_i;
          irq_q <= 1'b1;
        end
      end else if (tick_i) begin
        if (cnt_q == '1) begin
          cnt_q <= '0;
          dly_q <= DLY_LOAD;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign dly_o = dly_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/div_timer.sv
module div_timer
  import timer_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF04,
  parameter int unsigned DIV_W        = 16,
  parameter int unsigned RELOAD_DELAY = 4,
  localparam int unsigned DLY_W = $clog2(RELOAD_DELAY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              hit;
  reg_sel_e          sel;
  logic              wr_div, wr_cnt, wr_mod, wr_ctl;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] cnt_q, tma_q;
  logic [DLY_W-1:0]  dly_q;
  ctl_t              ctl_q;
  logic [NUM_TAPS-1:0] taps;
  logic              tick;

  // window is four aligned bytes
  assign hit = (addr_i[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
  assign sel = reg_sel_e'(addr_i[1:0]);

  assign wr_div = we_i && hit && (sel == RegDiv);
  assign wr_cnt = we_i && hit && (sel == RegCnt);
  assign wr_mod = we_i && hit && (sel == RegMod);
  assign wr_ctl = we_i && hit && (sel == RegCtl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tma_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_mod) tma_q <= wdata_i;
      if (wr_ctl) ctl_q <= ctl_t'(wdata_i[2:0]);
    end
  end

  timer_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (wr_div),
    .div_o (div_q)
  );

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int unsigned IDX = tap_bit(g);
    assign taps[g] = div_q[IDX];
  end

  timer_tap_edge #(.NUM_TAPS(NUM_TAPS)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .taps_i(taps),
    .en_i  (ctl_q.en),
    .rate_i(ctl_q.rate),
    .tick_o(tick)
  );

  timer_counter #(.W(DATA_W), .DELAY(RELOAD_DELAY)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .wr_i   (wr_cnt),
    .wdata_i(wdata_i),
    .mod_i  (tma_q),
    .cnt_o  (cnt_q),
    .dly_o  (dly_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (sel)
        RegDiv: rdata_o = div_q[DIV_W-1 -: DATA_W];
        RegCnt: rdata_o = cnt_q;
        RegMod: rdata_o = tma_q;
        RegCtl: rdata_o = {5'b11111, ctl_q};
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF04,
  parameter int unsigned DIV_W = 16,
  parameter int unsigned DLY_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              irq_o,
  input logic [DIV_W-1:0]  div_q,
  input logic [7:0]        cnt_q,
  input logic [7:0]        tma_q,
  input logic [DLY_W-1:0]  dly_q,
  input logic              tick
);
  localparam logic [ADDR_W-1:0] A_CNT = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTL = BASE_ADDR + ADDR_W'(3);

  logic in_win, wr_div_c, wr_cnt_c;
  assign in_win   = (addr_i >= BASE_ADDR) && (addr_i <= A_CTL);
  assign wr_div_c = we_i && (addr_i == BASE_ADDR);
  assign wr_cnt_c = we_i && (addr_i == A_CNT);

  AST_DIV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_div_c |=> div_q == $past(div_q) + 1'b1); // R2
  AST_DIV_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == BASE_ADDR) |-> rdata_o == div_q[DIV_W-1 -: 8]); // R2
  AST_DIV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_div_c |=> div_q == '0); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q == '0 && !tick && !wr_cnt_c) |=> cnt_q == $past(cnt_q)); // R5
  AST_ZERO_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q != '0) |-> cnt_q == 8'h00); // R6
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q == DLY_W'(1) && !wr_cnt_c) |=> irq_o && cnt_q == $past(tma_q)); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R6
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_c |=> cnt_q == $past(wdata_i) && !irq_o && dly_q == '0); // R8
  AST_DELAY_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q != '0 && !wr_cnt_c) |=> dly_q == $past(dly_q) - 1'b1); // R11
  AST_CTL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTL) |-> rdata_o[7:3] == 5'h1F); // R10
  AST_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> rdata_o == 8'h00); // R10
endmodule

bind div_timer timer_checker #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .DIV_W(DIV_W), .DLY_W(DLY_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .div_q  (div_q),
  .cnt_q  (cnt_q),
  .tma_q  (tma_q),
  .dly_q  (dly_q),
  .tick   (tick)
);

// File: tb/tb_div_timer.sv
`timescale 1ns/1ps
module tb_div_timer;
  localparam logic [15:0] A_DIV = 16'hFF04;
  localparam logic [15:0] A_CNT = 16'hFF05;
  localparam logic [15:0] A_MOD = 16'hFF06;
  localparam logic [15:0] A_CTL = 16'hFF07;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        we;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  div_timer dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .we_i   (we),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_to(inout int t, input int target);
    idle(target - t);
    t = target;
  endtask

  task automatic see(input string req, input string what, input logic [7:0] exp_cnt, input logic exp_irq);
    logic [7:0] v;
    rd(A_CNT, v);
    chk(req, {what, " cnt"}, v, exp_cnt);
    chk(req, {what, " irq"}, irq, exp_irq);
  endtask

  // leaves divider at 1 and counting enabled
  task automatic arm(input logic [1:0] rate, input logic [7:0] cnt, input logic [7:0] md);
    wr(A_CTL, {6'b0, rate});
    wr(A_MOD, md);
    wr(A_CNT, cnt);
    wr(A_DIV, 8'hC3);
    wr(A_CTL, {5'b0, 1'b1, rate});
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int t;
    rst_n = 1'b0; we = 1'b0; addr = A_DIV; wdata = 8'h00;
    idle(3);

    // R1 reset state
    rd(A_DIV, v); chk("R1", "div", v, 8'h00);
    rd(A_CNT, v); chk("R1", "cnt", v, 8'h00);
    rd(A_MOD, v); chk("R1", "mod", v, 8'h00);
    rd(A_CTL, v); chk("R1", "ctl", v, 8'hF8);
    chk("R1", "irq", irq, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 R3 divider view and clear with ignored data
    wr(A_DIV, 8'hFF); t = 0;
    rd(A_DIV, v); chk("R3", "div after clear", v, 8'h00);
    go_to(t, 255); rd(A_DIV, v); chk("R2", "div at 255", v, 8'h00);
    go_to(t, 256); rd(A_DIV, v); chk("R2", "div at 256", v, 8'h01);
    go_to(t, 700); rd(A_DIV, v); chk("R2", "div at 700", v, 8'h02);

    // R4 every rate, at both sides of first and third period
    for (int r = 0; r < 4; r++) begin
      int p;
      p = 1 << (((r == 0) ? 9 : 2 * r + 1) + 1);
      arm(r[1:0], 8'h00, 8'h00); t = 1;
      go_to(t, p);       see("R4", $sformatf("rate%0d t=P", r), 8'd0, 1'b0);
      go_to(t, p + 1);   see("R4", $sformatf("rate%0d t=P+1", r), 8'd1, 1'b0);
      go_to(t, 3 * p);   see("R4", $sformatf("rate%0d t=3P", r), 8'd2, 1'b0);
      rd(A_DIV, v); chk("R2", $sformatf("rate%0d div", r), v, (3 * p) >> 8);
      go_to(t, 3 * p + 1); see("R4", $sformatf("rate%0d t=3P+1", r), 8'd3, 1'b0);
    end

    // R5 disabled counter holds
    wr(A_CTL, 8'h01);
    wr(A_CNT, 8'h40);
    idle(300);
    see("R5", "disabled", 8'h40, 1'b0);

    // R6 wrap, four zero cycles, reload with single irq
    arm(2'b01, 8'hFE, 8'hA5); t = 1;
    go_to(t, 16); see("R6", "t16", 8'hFE, 1'b0);
    go_to(t, 17); see("R6", "t17", 8'hFF, 1'b0);
    go_to(t, 32); see("R6", "t32", 8'hFF, 1'b0);
    for (int k = 33; k <= 36; k++) begin
      go_to(t, k); see("R6", $sformatf("zero t%0d", k), 8'h00, 1'b0);
    end
    go_to(t, 37); see("R6", "reload", 8'hA5, 1'b1);
    go_to(t, 38); see("R6", "after reload", 8'hA5, 1'b0);

    // R7 write during pending reload cancels it
    arm(2'b01, 8'hFE, 8'hA5); t = 1;
    go_to(t, 35); see("R7", "pending", 8'h00, 1'b0);
    wr(A_CNT, 8'h33); t = 36;
    for (int k = 36; k <= 40; k++) begin
      go_to(t, k); see("R7", $sformatf("cancel t%0d", k), 8'h33, 1'b0);
    end

    // R8 write on the tick cycle wins
    arm(2'b01, 8'hFE, 8'hA5); t = 1;
    go_to(t, 32);
    wr(A_CNT, 8'h10); t = 33;
    for (int k = 33; k <= 38; k++) begin
      go_to(t, k); see("R8", $sformatf("priority t%0d", k), 8'h10, 1'b0);
    end

    // R9 disabling while tap high yields one step
    wr(A_CTL, 8'h00);
    wr(A_CNT, 8'h20);
    wr(A_DIV, 8'h00); t = 0;
    go_to(t, 600);
    wr(A_CTL, 8'h04);
    wr(A_CTL, 8'h00);
    idle(1); see("R9", "extra step", 8'h21, 1'b0);
    idle(100); see("R9", "then idle", 8'h21, 1'b0);

    // R11 counting edge inside the reload window is dropped
    wr(A_CTL, 8'h00);
    wr(A_MOD, 8'h77);
    wr(A_CNT, 8'hFF);
    wr(A_DIV, 8'h00); t = 0;
    go_to(t, 600);
    wr(A_CTL, 8'h04);
    wr(A_CTL, 8'h00);
    wr(A_CTL, 8'h04); see("R11", "wrapped", 8'h00, 1'b0);
    wr(A_CTL, 8'h00); see("R11", "edge in window", 8'h00, 1'b0);
    idle(1); see("R11", "window 2", 8'h00, 1'b0);
    idle(1); see("R11", "window 1", 8'h00, 1'b0);
    idle(1); see("R11", "reload", 8'h77, 1'b1);
    idle(5); see("R11", "steady", 8'h77, 1'b0);

    // R10 exhaustive readback
    for (int x = 0; x < 256; x++) begin
      wr(A_MOD, x[7:0]); rd(A_MOD, v);
      chk("R10", $sformatf("mod %0h", x), v, x);
    end
    for (int x = 0; x < 256; x++) begin
      wr(A_CTL, x[7:0]); rd(A_CTL, v);
      chk("R10", $sformatf("ctl %0h", x), v, x | 8'hF8);
    end
    // R10 outside window
    wr(A_CTL, 8'h00);
    wr(A_CNT, 8'h12);
    wr(A_MOD, 8'h34);
    wr(16'hFF08, 8'hFF);
    wr(16'hFF03, 8'hFF);
    wr(16'h0005, 8'hEE);
    rd(16'hFF08, v); chk("R10", "read ff08", v, 8'h00);
    rd(16'hFF03, v); chk("R10", "read ff03", v, 8'h00);
    rd(A_CNT, v); chk("R10", "cnt kept", v, 8'h12);
    rd(A_MOD, v); chk("R10", "mod kept", v, 8'h34);
    rd(A_CTL, v); chk("R10", "ctl kept", v, 8'hF8);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule